// File: doc/BRIEF.md
# Software-Clocked PHY Configuration Register Port

This block sits behind a single 32-bit control register on a simple write bus and turns the words software stores there into writes to a small configuration register file. The file holds one array of 8-bit registers for each PHY port, up to two ports. Software does not get a write strobe. Instead it toggles a test-clock bit inside the word itself. The block commits a write only when that bit goes from low to high between two accepted words. Write enable and an active-low test reset also travel in the same word.

A full register write costs three bus writes. First software stores the word with its fields set and the test clock low. Then it stores the same word with the clock high, and finally the word with the clock low again. Bit 2 of register 0x06 of port 0 drives the PHY clock-enable output.

Each committed write is reported on a one-cycle event output carrying its port, address and data, so that surrounding logic can follow the configuration as it changes. The bus input uses a valid/ready pair. Ready is always high, so the block never applies back-pressure, and a word counts as accepted in every cycle where valid is high. The event output has no ready: it is a notification that cannot be stalled.

Top module: `tstctl_top`

## Requirements
- R1: Within an accepted word, bits [7:0] are the data, bits [15:8] the register address and bits [18:16] the port number. A committed write stores that data at that address of that port, and the event output reports the same three values.
- R2: A write is committed only by an accepted word whose bit 22 is 1 when bit 22 of the previously accepted word was 0. After hardware reset the remembered value of bit 22 is 0.
- R3: A rising edge on bit 22 in a word whose bit 21 (write enable) is 0 changes no register and produces no event.
- R4: An accepted word with bit 23 at 0 clears every register of every port to zero in the cycle it is accepted. Until a word with bit 23 at 1 is accepted, no write is committed. After hardware reset all registers read zero and the test reset counts as asserted.
- R5: `phy_clk_en` equals bit 2 of register 0x06 of port 0. No register of port 1 affects it.
- R6: A rising edge that addresses a port number of 2 or higher (NPORTS or higher) is dropped: no register changes and no event is produced.
- R7: Accepted words that keep bit 22 high produce no further writes. The low/high/low three-word sequence produces exactly one write.
- R8: `bus_ready` is 1 in every cycle after reset. `cw_valid` pulses for exactly one cycle, in the cycle after the committing word is accepted, and the register contents are updated by that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| bus_valid | input | 1 | A control word is presented |
| bus_ready | output | 1 | Always 1; the block never stalls the bus |
| bus_wdata | input | 32 | Control word |
| phy_clk_en | output | 1 | PHY clock enable: port 0, register 0x06, bit 2 |
| cw_valid | output | 1 | One-cycle pulse for each committed write |
| cw_port | output | 3 | Port of the committed write |
| cw_addr | output | 8 | Register address of the committed write |
| cw_data | output | 8 | Data of the committed write |

## Verification
The bench repeats the high test-clock word several times. A design that reacted to level instead of edge would commit a write on every one of those words and produce extra events. It sends rising edges with the write enable low, and with port numbers 2 and 7. A design that ignored either condition would toggle the clock-enable output or report a write that never should have happened. It asserts the test reset after the clock enable has been set and then attempts a write while the reset is still held. A design that only blocked writes without clearing, or cleared without blocking, would leave the clock enable at 1 or emit an event. It also writes to register 0x06 of port 1, where a design that decoded the port wrongly would move the clock-enable output.

// File: rtl/tstctl_pkg.sv
package tstctl_pkg;
  localparam int WORD_W   = 32;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int PORT_W   = 3;
  localparam int DATA_LSB = 0;
  localparam int ADDR_LSB = 8;
  localparam int PORT_LSB = 16;
  localparam int WE_BIT   = 21;
  localparam int TCK_BIT  = 22;
  localparam int TRST_BIT = 23;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/tstctl_decode.sv
module tstctl_decode
  import tstctl_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              commit,
  output logic              clear,
  output wr_cmd_t           cmd
);
  logic prev_tck_q;
  logic trst_n_q;
  logic rise;
  logic port_ok;

  always_comb begin
    cmd.data = word[DATA_LSB +: DATA_W];
    cmd.addr = word[ADDR_LSB +: ADDR_W];
    cmd.port = word[PORT_LSB +: PORT_W];
    port_ok  = (int'(cmd.port) < NPORTS);
    rise     = valid && word[TCK_BIT] && !prev_tck_q;
    clear    = valid ? !word[TRST_BIT] : !trst_n_q;
    commit   = rise && word[WE_BIT] && word[TRST_BIT] && port_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_tck_q <= 1'b0;
      trst_n_q   <= 1'b0;
    end else if (valid) begin
      prev_tck_q <= word[TCK_BIT];
      trst_n_q   <= word[TRST_BIT];
    end
  end
endmodule

// File: rtl/tstctl_portregs.sv
module tstctl_portregs
  import tstctl_pkg::*;
#(
  parameter int TAP_EN  = 0,
  parameter int TAP_REG = 6,
  parameter int TAP_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              tap
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[addr] <= data;
    end
  end

  generate
    if (TAP_EN != 0) begin : g_tap
      assign tap = regs[TAP_REG][TAP_BIT];
    end else begin : g_notap
      assign tap = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tstctl_top.sv
module tstctl_top
  import tstctl_pkg::*;
#(
  parameter int NPORTS     = 2,
  parameter int CLKEN_REG  = 6,
  parameter int CLKEN_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              phy_clk_en,
  output logic              cw_valid,
  output logic [PORT_W-1:0] cw_port,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [DATA_W-1:0] cw_data
);
  logic        commit;
  logic        clear;
  wr_cmd_t     cmd;
  wr_cmd_t     cw_q;
  logic        cw_valid_q;
  logic [NPORTS-1:0] taps;

  assign bus_ready = 1'b1;

  tstctl_decode #(.NPORTS(NPORTS)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (bus_valid),
    .word   (bus_wdata),
    .commit (commit),
    .clear  (clear),
    .cmd    (cmd)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      tstctl_portregs #(
        .TAP_EN  ((p == 0) ? 1 : 0),
        .TAP_REG (CLKEN_REG),
        .TAP_BIT (CLKEN_BIT)
      ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .we    (commit && (int'(cmd.port) == p)),
        .addr  (cmd.addr),
        .data  (cmd.data),
        .tap   (taps[p])
      );
    end
  endgenerate

  assign phy_clk_en = |taps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw_valid_q <= 1'b0;
      cw_q       <= '0;
    end else begin
      cw_valid_q <= commit;
      if (commit) cw_q <= cmd;
    end
  end

  assign cw_valid = cw_valid_q;
  assign cw_port  = cw_q.port;
  assign cw_addr  = cw_q.addr;
  assign cw_data  = cw_q.data;
endmodule

// File: rtl/tstctl_chk.sv
module tstctl_chk
  import tstctl_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              phy_clk_en,
  input logic              cw_valid,
  input logic [PORT_W-1:0] cw_port,
  input logic [ADDR_W-1:0] cw_addr,
  input logic [DATA_W-1:0] cw_data
);
  // R2, R3, R4: an event needs a preceding accepted word with clock, enable and reset-release high
  p_event_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> $past(bus_valid && bus_wdata[TCK_BIT] && bus_wdata[WE_BIT] && bus_wdata[TRST_BIT]));

  // R6: events only for existing ports
  p_port_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> (int'(cw_port) < NPORTS));

  // R4: a test-reset word forces the clock enable low
  p_reset_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_wdata[TRST_BIT]) |=> !phy_clk_en);

  // R5: a write to port 0 register 6 sets the clock enable from bit 2
  p_clken_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_port == 3'd0 && cw_addr == 8'd6) |-> (phy_clk_en == cw_data[2]));

  // R5, R4: the clock enable only moves after a write or a test reset
  p_clken_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phy_clk_en) |-> (cw_valid || $past(bus_valid && !bus_wdata[TRST_BIT])));

  // R7: two consecutive events are impossible (a rise needs a low word in between)
  p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |=> !cw_valid);

  // R8: the bus is never stalled
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n) bus_ready);
endmodule

bind tstctl_top tstctl_chk #(.NPORTS(NPORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_wdata  (bus_wdata),
  .phy_clk_en (phy_clk_en),
  .cw_valid   (cw_valid),
  .cw_port    (cw_port),
  .cw_addr    (cw_addr),
  .cw_data    (cw_data)
);

// File: tb/tb_tstctl_top.sv
module tb_tstctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic        phy_clk_en;
  logic        cw_valid;
  logic [2:0]  cw_port;
  logic [7:0]  cw_addr;
  logic [7:0]  cw_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] p;
    logic [7:0] a;
    logic [7:0] d;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  tstctl_top dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_wdata(bus_wdata), .phy_clk_en(phy_clk_en), .cw_valid(cw_valid),
    .cw_port(cw_port), .cw_addr(cw_addr), .cw_data(cw_data)
  );

  function automatic logic [31:0] mk(input logic [2:0] p, input logic [7:0] a,
                                     input logic [7:0] d, input bit we,
                                     input bit tck, input bit trst_n);
    mk = '0;
    mk[7:0]   = d;
    mk[15:8]  = a;
    mk[18:16] = p;
    mk[21]    = we;
    mk[22]    = tck;
    mk[23]    = trst_n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_wdata = w;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // three-word write; pushes an expected event when one should occur
  task automatic wr(input logic [2:0] p, input logic [7:0] a, input logic [7:0] d,
                    input bit we, input bit expect_ev, input string tag);
    exp_t e;
    put(mk(p, a, d, we, 1'b0, 1'b1));
    if (expect_ev) begin
      e.p = p; e.a = a; e.d = d; e.tag = tag;
      expq.push_back(e);
    end
    put(mk(p, a, d, we, 1'b1, 1'b1));
    put(mk(p, a, d, we, 1'b0, 1'b1));
  endtask

  // monitor: pops the scoreboard on every event
  always @(negedge clk) begin
    if (rst_n && cw_valid) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2/R3/R6 unexpected event: actual p=%0d a=%0h d=%0h expected none",
                 cw_port, cw_addr, cw_data);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check({e.tag, " R1 event"}, {13'd0, cw_port, cw_addr, cw_data},
              {13'd0, e.p, e.a, e.d});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset clk_en", 32'(phy_clk_en), 0);
    check("R8 reset cw_valid", 32'(cw_valid), 0);
    check("R8 ready", 32'(bus_ready), 1);

    // R5: set clock enable
    wr(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, "R5");
    check("R5 clk_en set", 32'(phy_clk_en), 1);
    // R5: port 1 register 6 does not drive it
    wr(3'd1, 8'h06, 8'h00, 1'b1, 1'b1, "R5");
    check("R5 port1 no effect", 32'(phy_clk_en), 1);
    wr(3'd0, 8'h06, 8'hFB, 1'b1, 1'b1, "R5");
    check("R5 clk_en clear", 32'(phy_clk_en), 0);
    wr(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, "R5");
    check("R5 clk_en reset", 32'(phy_clk_en), 1);

    // R6: nonexistent ports dropped
    wr(3'd2, 8'h06, 8'h00, 1'b1, 1'b0, "R6");
    check("R6 port2 dropped", 32'(phy_clk_en), 1);
    wr(3'd7, 8'h06, 8'h00, 1'b1, 1'b0, "R6");
    check("R6 port7 dropped", 32'(phy_clk_en), 1);

    // R3: enable low
    wr(3'd0, 8'h06, 8'h00, 1'b0, 1'b0, "R3");
    check("R3 we low no write", 32'(phy_clk_en), 1);

    // R7: clock held high across several words
    begin
      exp_t e;
      put(mk(3'd0, 8'h06, 8'h00, 1'b1, 1'b0, 1'b1));
      e.p = 3'd0; e.a = 8'h06; e.d = 8'h00; e.tag = "R7";
      expq.push_back(e);
      put(mk(3'd0, 8'h06, 8'h00, 1'b1, 1'b1, 1'b1));
      check("R7 first high writes", 32'(phy_clk_en), 0);
      put(mk(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, 1'b1));
      put(mk(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, 1'b1));
      check("R7 held high no write", 32'(phy_clk_en), 0);
      put(mk(3'd0, 8'h06, 8'h04, 1'b1, 1'b0, 1'b1));
      check("R7 falling no write", 32'(phy_clk_en), 0);
    end

    // R1: field positions
    wr(3'd1, 8'hA5, 8'h3C, 1'b1, 1'b1, "R1");
    wr(3'd0, 8'h5A, 8'hC3, 1'b1, 1'b1, "R1");

    // R4: test reset clears and blocks
    wr(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, "R4");
    check("R4 pre clk_en", 32'(phy_clk_en), 1);
    put(mk(3'd0, 8'h06, 8'h04, 1'b1, 1'b0, 1'b0));
    check("R4 test reset clears", 32'(phy_clk_en), 0);
    put(mk(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, 1'b0));
    put(mk(3'd0, 8'h06, 8'h04, 1'b1, 1'b0, 1'b0));
    check("R4 blocked write", 32'(phy_clk_en), 0);
    wr(3'd0, 8'h06, 8'h04, 1'b1, 1'b1, "R4");
    check("R4 after release", 32'(phy_clk_en), 1);
    check("R8 ready end", 32'(bus_ready), 1);

    repeat (3) @(negedge clk);
    check("R8 all events seen", expq.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule